// File: doc/BRIEF.md
# Integer ALU with Zero/Carry Flags and Branch Condition Check

This block is the integer arithmetic stage of a small in-order pipeline. In one cycle it takes two operands, the destination register's current contents and an operation code, and produces a 32-bit result together with a register-file write strobe. It owns a two-bit status register that holds a zero flag and a carry flag. Whenever a legal operation is accepted, that register is loaded at the next clock edge.

A separate condition input selects one of five branch tests. The test is evaluated against the flag register as it stands in the current cycle, so a branch that is issued after a flag-setting operation sees that operation's flags. The operand order is deliberate. Subtract and compare compute the second operand minus the first. Single-operand operations (shifts, increment, decrement) read only the first operand. For add, subtract, compare, increment and decrement, the carry is derived by comparing the destination's previous value with the first operand, not from the adder's carry-out.

Top module: `flag_alu`

## Requirements
- R1: Op code 0 (add) drives `result` = `opnd_a + opnd_b` modulo 2^32, and the carry flag it loads is 1 exactly when `dest_old < opnd_a` (unsigned).
- R2: Op code 1 (subtract) drives `result` = `opnd_b - opnd_a` modulo 2^32, and the carry flag it loads is 1 exactly when `dest_old > opnd_a` (unsigned).
- R3: Op code 2 (compare) loads the same flags as subtract on the same inputs, and it never raises `wr_en`.
- R4: Op code 3 shifts `opnd_a` left by one and op code 4 shifts it right by one; both are logical (a zero fills the vacated bit), and the carry loaded is the bit shifted out (bit 31 for left, bit 0 for right).
- R5: Op code 5 drives `opnd_a + 1` and op code 6 drives `opnd_a - 1`, both modulo 2^32; for both, the carry loaded is 1 exactly when `dest_old > opnd_a`.
- R6: For every legal op code, the zero flag loaded is 1 exactly when the 32-bit result is zero.
- R7: `flags` bit 0 is zero and bit 1 is carry; both are 0 after reset. They are loaded at the rising edge only when `op_valid` is high and the op code is legal (0 to 6). In every other cycle they hold their value.
- R8: `wr_en` is high exactly when `op_valid` and `wb_req` are both high and the op code is legal and not compare. With `wb_req` low, the flags are still loaded.
- R9: `cond_true` is combinational from `cond_sel` and the current `flags`: code 0 gives always 1, code 1 gives Z, code 2 gives not Z, code 3 gives C, code 4 gives not C, and codes 5 to 7 give 0.
- R10: With `op_valid` high and an op code of 7 to 15, `illegal_op` is high, `wr_en` is low and the flags are unchanged. `illegal_op` is low whenever `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select (0 to 6 legal) |
| cond_sel | input | 3 | Branch condition select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| dest_old | input | 32 | Current value of the destination register |
| wb_req | input | 1 | Writeback of the result requested |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination register write strobe |
| flags | output | 2 | Status register: bit 0 zero, bit 1 carry |
| cond_true | output | 1 | Selected branch condition holds |
| illegal_op | output | 1 | Valid operation with an unsupported op code |

## Verification
On every cycle, the assertions check four relations: compare and illegal codes never strobe a write, flags stay put unless an operation is accepted, the zero flag follows the previous cycle's result, and a left shift's carry is the old top bit. The exact arithmetic of each operation cannot be shown this way. That includes the reversed subtract order, wrap-around at 0 and 2^32-1, and the carry rules that depend on `dest_old`. The same holds for the full mapping of condition codes, including the unused codes. These are shown only by the bench's vector table and directed scenarios, which compare against values worked out by hand.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int FLAG_W  = 2;
  localparam int FLAG_Z  = 0;
  localparam int FLAG_C  = 1;
  localparam int OP_W    = 4;
  localparam int COND_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_SHL = 4'd3,
    OP_SHR = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6
  } alu_op_e;

  typedef enum logic [COND_W-1:0] {
    CC_ALWAYS = 3'd0,
    CC_ZERO   = 3'd1,
    CC_NZERO  = 3'd2,
    CC_CARRY  = 3'd3,
    CC_NCARRY = 3'd4
  } cond_e;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return op <= OP_DEC;
  endfunction

  function automatic logic op_stores(input logic [OP_W-1:0] op);
    return op_known(op) && (op != OP_CMP);
  endfunction

endpackage

// File: rtl/flag_alu_datapath.sv
module flag_alu_datapath
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op_code,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [W-1:0]    dest_old,
  output logic [W-1:0]    res,
  output logic            carry_nx,
  output logic            zero_nx,
  output logic            legal
);

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] f_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [W-1:0] f_rsub(input logic [W-1:0] x, input logic [W-1:0] y);
    return y - x;
  endfunction

  function automatic logic [W-1:0] f_shl1(input logic [W-1:0] x);
    return {x[W-2:0], 1'b0};
  endfunction

  function automatic logic [W-1:0] f_shr1(input logic [W-1:0] x);
    return {1'b0, x[W-1:1]};
  endfunction

  logic dest_lt_a;
  logic dest_gt_a;

  assign dest_lt_a = dest_old < opnd_a;
  assign dest_gt_a = dest_old > opnd_a;

  always_comb begin
    res      = '0;
    carry_nx = 1'b0;
    legal    = 1'b1;
    case (op_code)
      OP_ADD: begin
        res      = f_add(opnd_a, opnd_b);
        carry_nx = dest_lt_a;
      end
      OP_SUB, OP_CMP: begin
        res      = f_rsub(opnd_a, opnd_b);
        carry_nx = dest_gt_a;
      end
      OP_SHL: begin
        res      = f_shl1(opnd_a);
        carry_nx = opnd_a[W-1];
      end
      OP_SHR: begin
        res      = f_shr1(opnd_a);
        carry_nx = opnd_a[0];
      end
      OP_INC: begin
        res      = f_add(opnd_a, ONE);
        carry_nx = dest_gt_a;
      end
      OP_DEC: begin
        res      = f_rsub(ONE, opnd_a);
        carry_nx = dest_gt_a;
      end
      default: legal = 1'b0;
    endcase
  end

  assign zero_nx = (res == '0);

endmodule

// File: rtl/flag_alu_flagreg.sv
module flag_alu_flagreg
  import flag_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              zero_in,
  input  logic              carry_in,
  output logic [FLAG_W-1:0] flags_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (load) begin
      flags_q[FLAG_Z] <= zero_in;
      flags_q[FLAG_C] <= carry_in;
    end
  end

endmodule

// File: rtl/flag_alu_cond.sv
module flag_alu_cond
  import flag_alu_pkg::*;
(
  input  logic [COND_W-1:0] cond_sel,
  input  logic [FLAG_W-1:0] flags_q,
  output logic              taken
);

  always_comb begin
    case (cond_sel)
      CC_ALWAYS: taken = 1'b1;
      CC_ZERO:   taken = flags_q[FLAG_Z];
      CC_NZERO:  taken = !flags_q[FLAG_Z];
      CC_CARRY:  taken = flags_q[FLAG_C];
      CC_NCARRY: taken = !flags_q[FLAG_C];
      default:   taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [2:0]        cond_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] dest_old,
  input  logic              wb_req,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [1:0]        flags,
  output logic              cond_true,
  output logic              illegal_op
);

  logic legal;
  logic zero_nx;
  logic carry_nx;
  logic op_accept;

  flag_alu_datapath #(.W(DATA_W)) u_dp (
    .op_code  (op_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .dest_old (dest_old),
    .res      (result),
    .carry_nx (carry_nx),
    .zero_nx  (zero_nx),
    .legal    (legal)
  );

  assign op_accept  = op_valid && legal;
  assign illegal_op = op_valid && !legal;
  assign wr_en      = op_accept && wb_req && op_stores(op_code);

  flag_alu_flagreg u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (op_accept),
    .zero_in  (zero_nx),
    .carry_in (carry_nx),
    .flags_q  (flags)
  );

  flag_alu_cond u_cond (
    .cond_sel (cond_sel),
    .flags_q  (flags),
    .taken    (cond_true)
  );

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_accept,
  input logic         wb_req,
  input logic [3:0]   op_code,
  input logic [2:0]   cond_sel,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic [1:0]   flags,
  input logic         cond_true,
  input logic         illegal_op
);

  p_cmp_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd2) |-> !wr_en);

  p_shl_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_accept && op_code == 4'd3) |=> (flags[1] == $past(opnd_a[W-1])));

  p_zero_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |=> (flags[0] == ($past(result) == '0)));

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_accept |=> $stable(flags));

  p_write_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (op_valid && wb_req));

  p_always_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 3'd0) |-> cond_true);

  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (!wr_en && !op_accept));

endmodule

bind flag_alu flag_alu_chk #(.W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_accept  (op_accept),
  .wb_req     (wb_req),
  .op_code    (op_code),
  .cond_sel   (cond_sel),
  .opnd_a     (opnd_a),
  .result     (result),
  .wr_en      (wr_en),
  .flags      (flags),
  .cond_true  (cond_true),
  .illegal_op (illegal_op)
);

// File: tb/flag_alu_test.sv
`timescale 1ns/100ps
module flag_alu_test;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] d;
    logic [31:0] res;
    logic [1:0]  fl;   // {C,Z}
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{4'd0, 32'd5,          32'd7,  32'd0,          32'd12,         2'b10},
    '{4'd0, 32'd0,          32'd0,  32'd0,          32'd0,          2'b01},
    '{4'd0, 32'hFFFF_FFFF,  32'd1,  32'hFFFF_FFFF,  32'd0,          2'b01},
    '{4'd1, 32'd3,          32'd10, 32'd9,          32'd7,          2'b10},
    '{4'd1, 32'd4,          32'd4,  32'd0,          32'd0,          2'b01},
    '{4'd2, 32'd6,          32'd6,  32'd7,          32'd0,          2'b11},
    '{4'd3, 32'h8000_0001,  32'd0,  32'd0,          32'h0000_0002,  2'b10},
    '{4'd3, 32'h8000_0000,  32'd0,  32'd0,          32'd0,          2'b11},
    '{4'd4, 32'd3,          32'd0,  32'd0,          32'd1,          2'b10},
    '{4'd4, 32'd2,          32'd0,  32'd0,          32'd1,          2'b00},
    '{4'd5, 32'hFFFF_FFFF,  32'd0,  32'd0,          32'd0,          2'b01},
    '{4'd5, 32'd9,          32'd0,  32'd20,         32'd10,         2'b10},
    '{4'd6, 32'd1,          32'd0,  32'd5,          32'd0,          2'b11},
    '{4'd6, 32'd0,          32'd0,  32'd0,          32'hFFFF_FFFF,  2'b00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [2:0]  cond_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] dest_old = '0;
  logic        wb_req = 1'b0;
  logic [31:0] result;
  logic        wr_en;
  logic [1:0]  flags;
  logic        cond_true;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flag_alu uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cond_sel(cond_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .dest_old(dest_old), .wb_req(wb_req), .result(result), .wr_en(wr_en),
    .flags(flags), .cond_true(cond_true), .illegal_op(illegal_op)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1 add";
      4'd1: return "R2 sub";
      4'd2: return "R3 cmp";
      4'd3, 4'd4: return "R4 shift";
      default: return "R5 inc/dec";
    endcase
  endfunction

  // drive on negedge, check combinational outputs, then flags after the edge
  task automatic run_op(input logic v, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] d, input logic wb);
    @(negedge clk);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b; dest_old = d; wb_req = wb;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  task automatic cond_sweep(input logic [1:0] fl);
    for (int c = 0; c < 8; c++) begin
      logic e;
      cond_sel = 3'(c);
      #0.2;
      case (c)
        0: e = 1'b1;
        1: e = fl[0];
        2: e = !fl[0];
        3: e = fl[1];
        4: e = !fl[1];
        default: e = 1'b0;
      endcase
      check("R9 condition", {31'd0, cond_true}, {31'd0, e});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset flags", {30'd0, flags}, 32'd0);
    check("R8 reset wr_en", {31'd0, wr_en}, 32'd0);
    check("R10 reset illegal", {31'd0, illegal_op}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(1'b1, VT[i].op, VT[i].a, VT[i].b, VT[i].d, 1'b1);
      check({tag_of(VT[i].op), " result"}, result, VT[i].res);
      check("R8 wr_en", {31'd0, wr_en}, {31'd0, VT[i].op != 4'd2});
      check("R10 no illegal", {31'd0, illegal_op}, 32'd0);
      after_edge();
      check({tag_of(VT[i].op), " carry"}, {31'd0, flags[1]}, {31'd0, VT[i].fl[1]});
      check("R6 zero flag", {31'd0, flags[0]}, {31'd0, VT[i].fl[0]});
    end

    // conditions with both flags set, then both clear
    run_op(1'b1, 4'd2, 32'd6, 32'd6, 32'd7, 1'b1);
    after_edge();
    check("R3 cmp flags", {30'd0, flags}, 32'd3);
    cond_sweep(2'b11);
    run_op(1'b1, 4'd4, 32'd2, 32'd0, 32'd0, 1'b1);
    after_edge();
    check("R4 shr flags", {30'd0, flags}, 32'd0);
    cond_sweep(2'b00);
    run_op(1'b1, 4'd0, 32'd0, 32'd0, 32'd5, 1'b1);
    after_edge();
    cond_sweep(2'b01);

    // valid low: nothing written, flags held (currently Z=1,C=0)
    run_op(1'b0, 4'd0, 32'd5, 32'd7, 32'd0, 1'b1);
    check("R8 wr_en without valid", {31'd0, wr_en}, 32'd0);
    check("R10 illegal without valid", {31'd0, illegal_op}, 32'd0);
    after_edge();
    check("R7 flags held", {30'd0, flags}, 32'd1);

    // illegal op codes
    for (int op = 7; op < 16; op++) begin
      run_op(1'b1, 4'(op), 32'd5, 32'd7, 32'd0, 1'b1);
      check("R10 illegal flagged", {31'd0, illegal_op}, 32'd1);
      check("R10 illegal no write", {31'd0, wr_en}, 32'd0);
      after_edge();
      check("R10 illegal flags kept", {30'd0, flags}, 32'd1);
    end

    // no writeback request: flags still load
    run_op(1'b1, 4'd0, 32'd5, 32'd7, 32'd0, 1'b0);
    check("R8 no wb_req", {31'd0, wr_en}, 32'd0);
    check("R1 result without wb", result, 32'd12);
    after_edge();
    check("R8 flags load without wb", {30'd0, flags}, 32'd2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule